// File: doc/BRIEF.md
# Bus Error Syndrome Capture Register

This block keeps a record of the first memory-access fault that an external bus master causes through a system-bus slave port. It holds a 32-bit syndrome word with an error-type field, a read/write indicator and two lock flags. Next to it sits a companion register that holds the address of the failing access. When a write access fails with a recognised error code and the syndrome is unlocked, the error type is stored and the field lock is set. When the address register is unlocked, the failing address is stored and the address lock is set. After that, later faults leave the stored contents unchanged.

Software sees the block through a simple register port. Reading either of the two status offsets returns the syndrome word. A write to the clear offset is a write-one-to-clear mask. A write to the set offset is a write-one-to-set mask, which lets a test force any implemented bit. The captured address can be read at a third offset. Bit numbers below use the convention where bit 0 is the most significant bit, so syndrome bit k sits at data-bus position 31−k.

Top module: `bus_err_syndrome`

## Requirements
- R1: After reset the syndrome word and the address register both read as zero.
- R2: Reading offset 0x40 or 0x44 returns the syndrome word. Reading 0x48 returns the address register. Any other offset reads zero. A write to 0x48 or to any other offset changes nothing.
- R3: Only bits 6 to 11 (data positions 25 down to 20, mask 0x03F00000) are implemented. All other bits read zero and ignore both the set mask and the clear mask.
- R4: A write to 0x40 clears each implemented bit whose mask bit is 1 and leaves the rest unchanged. The new value reads back on the next cycle.
- R5: A write to 0x44 sets each implemented bit whose mask bit is 1 and leaves the rest unchanged. The new value reads back on the next cycle.
- R6: A fault is captured when err_valid=1, err_write=1 and err_type is 001 (parity), 100 (protection) or 101 (unconfigured bank), and the field lock (bit 10, position 21) is 0. On the next cycle: bits 6..8 (positions 25..23, bit 6 most significant) hold err_type, bit 9 (position 22, read/write status) is 0, and the field lock is 1.
- R7: While the field lock is 1, a fault leaves bits 6..10 unchanged.
- R8: When the address lock (bit 11, position 20) is 0, a captured fault loads err_addr into the address register and sets the address lock. While the address lock is 1, the address register holds its value. Clearing the address lock through 0x40 re-arms address capture.
- R9: A fault with err_write=0 (a read access), or with a type code of 000, 01x or 11x, changes neither register.
- R10: When a clear write and a hardware capture touch the same bit in the same cycle, the clear wins and the bit reads 0. The address register is still loaded if the address lock was 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW (8) | Register byte offset |
| reg_wdata | input | 32 | Write mask or data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| err_valid | input | 1 | A bus fault is reported this cycle |
| err_write | input | 1 | 1 when the faulting access was a write |
| err_type | input | 3 | Fault type code |
| err_addr | input | EW (32) | Address of the faulting access |

## Verification
Read data is combinational, so reg_rdata reflects the register contents in the same cycle as the address. A clear, a set or a capture applied at one clock edge is visible on reg_rdata for the whole of the following cycle. The bench drives each cycle's inputs shortly after the falling edge. It compares reg_rdata against its model of the state from before that cycle's edge, and only then advances the model by one edge. The directed cases follow the same rule, so every expected value covers exactly one register stage.

// File: rtl/bus_err_syndrome.sv
module bus_err_syndrome #(
  parameter int          AW      = 8,
  parameter int          EW      = 32,
  parameter logic [7:0]  OFS_CLR = 8'h40,
  parameter logic [7:0]  OFS_SET = 8'h44,
  parameter logic [7:0]  OFS_ADR = 8'h48
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          err_valid,
  input  logic          err_write,
  input  logic [2:0]    err_type,
  input  logic [EW-1:0] err_addr
);
  localparam int TYPE_HI = 31 - 6;
  localparam int TYPE_LO = 31 - 8;
  localparam int RW_B    = 31 - 9;
  localparam int FL_B    = 31 - 10;
  localparam int AL_B    = 31 - 11;
  localparam logic [31:0] IMPL = (32'd1 << (TYPE_HI + 1)) - (32'd1 << AL_B);

  logic [31:0]   stat_q, stat_d;
  logic [EW-1:0] bear_q;

  wire known   = (err_type == 3'b001) || (err_type == 3'b100) || (err_type == 3'b101);
  wire cap     = err_valid & err_write & known;
  wire fld_cap = cap & ~stat_q[FL_B];
  wire adr_cap = cap & ~stat_q[AL_B];
  wire clr_hit = reg_we && (reg_addr == AW'(OFS_CLR));
  wire set_hit = reg_we && (reg_addr == AW'(OFS_SET));

  always_comb begin
    stat_d = stat_q;
    if (fld_cap) begin
      stat_d[TYPE_HI:TYPE_LO] = err_type;
      stat_d[RW_B]            = 1'b0;
      stat_d[FL_B]            = 1'b1;
    end
    if (adr_cap) stat_d[AL_B] = 1'b1;
    if (set_hit) stat_d = stat_d | (reg_wdata & IMPL);
    if (clr_hit) stat_d = stat_d & ~(reg_wdata & IMPL);
    stat_d = stat_d & IMPL;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      bear_q <= '0;
    end else begin
      stat_q <= stat_d;
      if (adr_cap) bear_q <= err_addr;
    end
  end

  assign reg_rdata = (reg_addr == AW'(OFS_CLR) || reg_addr == AW'(OFS_SET)) ? stat_q :
                     (reg_addr == AW'(OFS_ADR)) ? 32'(bear_q) : 32'd0;
endmodule

module bus_err_syndrome_chk #(
  parameter int          AW      = 8,
  parameter int          EW      = 32,
  parameter logic [7:0]  OFS_CLR = 8'h40,
  parameter logic [7:0]  OFS_SET = 8'h44
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [AW-1:0] reg_addr,
  input logic [31:0]   reg_wdata,
  input logic [31:0]   reg_rdata,
  input logic          err_valid,
  input logic          err_write,
  input logic [2:0]    err_type,
  input logic [31:0]   stat_q,
  input logic [EW-1:0] bear_q
);
  localparam logic [31:0] IMPL = 32'h03F0_0000;
  wire clr_w = reg_we && (reg_addr == AW'(OFS_CLR));
  wire set_w = reg_we && (reg_addr == AW'(OFS_SET));
  wire good  = (err_type == 3'b001) || (err_type == 3'b100) || (err_type == 3'b101);

  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == AW'(OFS_CLR)) |-> ((reg_rdata & ~IMPL) == 32'd0));
  a_r4_clear_mask: assert property (@(posedge clk) disable iff (!rst_n)
    clr_w |=> ((stat_q & $past(reg_wdata)) == 32'd0));
  a_r5_set_mask: assert property (@(posedge clk) disable iff (!rst_n)
    set_w |=> ((stat_q & $past(reg_wdata & IMPL)) == $past(reg_wdata & IMPL)));
  a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && err_write && good && !stat_q[21] && !reg_we) |=>
      (stat_q[21] && !stat_q[22] && stat_q[25:23] == $past(err_type)));
  a_r7_field_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[21] && !reg_we) |=> $stable(stat_q[25:21]));
  a_r8_addr_lock: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q[20] |=> $stable(bear_q));
  a_r9_read_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && !err_write && !reg_we) |=> ($stable(stat_q) && $stable(bear_q)));
endmodule

bind bus_err_syndrome bus_err_syndrome_chk #(.AW(AW), .EW(EW), .OFS_CLR(OFS_CLR), .OFS_SET(OFS_SET))
  u_chk (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
         .reg_rdata(reg_rdata), .err_valid(err_valid), .err_write(err_write), .err_type(err_type),
         .stat_q(stat_q), .bear_q(bear_q));

// File: tb/bus_err_syndrome_bench.sv
`timescale 1ns/1ps
module bus_err_syndrome_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        err_valid = 1'b0, err_write = 1'b0;
  logic [2:0]  err_type = 3'd0;
  logic [31:0] err_addr = '0;

  int errors = 0, checks = 0;
  logic [31:0] m_stat = '0, m_bear = '0;

  always #2 clk = ~clk;

  bus_err_syndrome u_bus_err_syndrome (.*);

  function automatic logic known_code(input logic [2:0] t);
    return (t == 3'b001) || (t == 3'b100) || (t == 3'b101);
  endfunction

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    if (a == 8'h40 || a == 8'h44) return m_stat;
    if (a == 8'h48) return m_bear;
    return 32'd0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic model_edge();
    logic [31:0] s = m_stat;
    logic cap = err_valid && err_write && known_code(err_type);
    if (cap && !m_stat[21]) begin
      s[25:23] = err_type; s[22] = 1'b0; s[21] = 1'b1;
    end
    if (cap && !m_stat[20]) begin
      s[20] = 1'b1; m_bear = err_addr;
    end
    if (reg_we && reg_addr == 8'h44) s = s | (reg_wdata & 32'h03F0_0000);
    if (reg_we && reg_addr == 8'h40) s = s & ~(reg_wdata & 32'h03F0_0000);
    m_stat = s;
  endtask

  task automatic cyc(input string req, input logic we, input logic [7:0] a, input logic [31:0] wd,
                     input logic ev, input logic ew, input logic [2:0] et, input logic [31:0] ea);
    @(negedge clk);
    reg_we = we; reg_addr = a; reg_wdata = wd;
    err_valid = ev; err_write = ew; err_type = et; err_addr = ea;
    #0.5;
    check(req, reg_rdata, exp_read(a));
    model_edge();
  endtask

  task automatic peek(input string req, input logic [7:0] a);
    cyc(req, 1'b0, a, 32'd0, 1'b0, 1'b0, 3'd0, 32'd0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    peek("R1", 8'h40); peek("R1", 8'h48);
    peek("R2", 8'h10);
    cyc("R3", 1'b1, 8'h44, 32'hFFFF_FFFF, 1'b0, 1'b0, 3'd0, 32'd0);
    peek("R3", 8'h40); peek("R2", 8'h44);
    cyc("R4", 1'b1, 8'h40, 32'h0280_0000, 1'b0, 1'b0, 3'd0, 32'd0);
    peek("R4", 8'h40);
    cyc("R4", 1'b1, 8'h40, 32'hFFFF_FFFF, 1'b0, 1'b0, 3'd0, 32'd0);
    cyc("R9", 1'b0, 8'h40, 32'd0, 1'b1, 1'b0, 3'b100, 32'hDEAD_0000);
    cyc("R9", 1'b0, 8'h40, 32'd0, 1'b1, 1'b1, 3'b010, 32'hDEAD_0004);
    cyc("R9", 1'b0, 8'h48, 32'd0, 1'b1, 1'b1, 3'b110, 32'hDEAD_0008);
    cyc("R6", 1'b0, 8'h40, 32'd0, 1'b1, 1'b1, 3'b101, 32'hCAFE_1000);
    cyc("R7", 1'b0, 8'h40, 32'd0, 1'b1, 1'b1, 3'b001, 32'hCAFE_2000);
    peek("R8", 8'h48); peek("R7", 8'h40);
    cyc("R2", 1'b1, 8'h48, 32'h1234_5678, 1'b0, 1'b0, 3'd0, 32'd0);
    peek("R2", 8'h48);
    cyc("R8", 1'b1, 8'h40, 32'h0010_0000, 1'b0, 1'b0, 3'd0, 32'd0);
    cyc("R8", 1'b0, 8'h40, 32'd0, 1'b1, 1'b1, 3'b100, 32'hBEEF_0010);
    peek("R8", 8'h48); peek("R8", 8'h40);
    cyc("R4", 1'b1, 8'h40, 32'hFFFF_FFFF, 1'b0, 1'b0, 3'd0, 32'd0);
    cyc("R10", 1'b1, 8'h40, 32'h03F0_0000, 1'b1, 1'b1, 3'b001, 32'hABCD_0000);
    peek("R10", 8'h40); peek("R10", 8'h48);
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] a;
      logic [31:0] wd;
      case ($urandom_range(0, 3))
        0: a = 8'h40; 1: a = 8'h44; 2: a = 8'h48; default: a = 8'($urandom_range(0, 255));
      endcase
      wd = ($urandom_range(0, 3) == 0) ? 32'hFFFF_FFFF : $urandom;
      cyc("R6", ($urandom_range(0, 5) == 0), a, wd, ($urandom_range(0, 2) == 0),
          ($urandom_range(0, 3) != 0), 3'($urandom_range(0, 7)), $urandom);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule